// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block sequences the two gate-enable outputs of one half-bridge channel in a synchronous buck converter. It reads a three-level switching command, a three-level enable command, a supply-good flag, two gate-off sense flags and a switch-node zero-cross flag. From these it decides, cycle by cycle, whether the high-side gate, the low-side gate or neither may be driven.

Every input arrives asynchronously and passes through a synchronizer chain first. A gate is switched on only once the opposite gate is sensed off, so the dead time adapts to the real gate discharge. A bounded wait stops a missing sense flag from hanging the sequence.

In the mid command state the channel runs in diode emulation. The low-side gate is held on for a fixed blanking time. After that it is cut off when the zero-cross flag reports zero or reverse inductor current, and both gates then stay off for the rest of that mid state. A mid enable level turns both gates off for body-diode braking. A low supply forces both gates off.

Top module: `gdrv_seq`

## Requirements
- R1: The switching and enable commands share one 2-bit encoding: 2'b10 is high, 2'b01 is mid and 2'b00 is low. The unused code 2'b11 is read as mid.
- R2: While `supply_ok` is low, both `hs_gate` and `ls_gate` are low. Once it returns high with enable high, the commands control the outputs again.
- R3: An enable of low drives both gate outputs low.
- R4: An enable of mid drives both gate outputs low, and changes of the switching command have no effect while it lasts.
- R5: On a high command, `hs_gate` rises only after `ls_gate` has been low for at least one cycle and the low-side gate is sensed off (`ls_off_sense` high). `hs_gate` is high only while the synchronized command is high.
- R6: On a low command, `ls_gate` rises only after `hs_gate` is low and the high-side gate is sensed off (`hs_off_sense` high).
- R7: If the awaited gate-off sense flag never arrives, the sequencer turns the other gate on after NOV_MAX_CYC cycles (default 8) in the waiting state.
- R8: On a mid command, `hs_gate` drops at once. After the high-side gate is sensed off, `ls_gate` rises and is held for exactly BLANK_CYC cycles. BLANK_CYC is 350 ns rounded up to whole clock periods, which is 18 at 50 MHz. `zc_detect` is ignored during this time.
- R9: After blanking, `ls_gate` falls when the synchronized `zc_detect` is high. It stays low for the rest of that mid state, whatever `zc_detect` does afterwards.
- R10: A high or low command clears the latched zero-cross state, so the next mid command blanks afresh.
- R11: `hs_gate` and `ls_gate` are never high in the same cycle.
- R12: A mid command that arrives while the low-side gate is on keeps `ls_gate` high without a gap and starts blanking at once.
- R13: A command change appears at the outputs no earlier than 3 clock edges after the input changes: two synchronizer stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_cmd | input | 2 | Three-level switching command (encoding as in R1) |
| en_cmd | input | 2 | Three-level enable command (encoding as in R1) |
| supply_ok | input | 1 | Driver supply above its lockout threshold |
| hs_off_sense | input | 1 | High-side gate voltage below its off level |
| ls_off_sense | input | 1 | Low-side gate voltage below its off level |
| zc_detect | input | 1 | Switch node shows zero or reverse inductor current |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
A command edge reaches the outputs on the third clock edge after the input changes: two synchronizer stages, then the state register.

Turn-on of the opposite gate then takes one more edge when its sense flag has been settled for a while. It takes three more edges when the sense flag follows the gate that was just switched off, because that flag must cross the synchronizer again. The forced timeout comes NOV_MAX_CYC edges after the wait state is entered. The blanked low-side pulse lasts BLANK_CYC edges.

The bench stamps the cycle at which it drives each stimulus and queues the expected gate pair for the exact cycles derived from these counts. This includes the last cycle before each transition, so an early or a late change is caught. Outputs are compared on the falling clock edge.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

   typedef enum logic [1:0] {
      CMD_LOW  = 2'b00,
      CMD_MID  = 2'b01,
      CMD_HIGH = 2'b10
   } cmd_e;

   typedef enum logic [3:0] {
      ST_OFF,
      ST_WAIT_HS,
      ST_HS_ON,
      ST_WAIT_LS,
      ST_LS_ON,
      ST_WAIT_MID,
      ST_MID_BLANK,
      ST_MID_ZC,
      ST_MID_DONE
   } seq_state_e;

   // the spare code 2'b11 is read as mid: both outputs of mid are the safer ones
   function automatic cmd_e decode_cmd(input logic [1:0] raw);
      case (raw)
         2'b10:   return CMD_HIGH;
         2'b00:   return CMD_LOW;
         default: return CMD_MID;
      endcase
   endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gdrv_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gdrv_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gdrv_timer.sv
module gdrv_timer #(
   parameter int CW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (clr)          cnt <= '0;
      else if (cnt != '1)    cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/gdrv_fsm.sv
module gdrv_fsm
   import gdrv_pkg::*;
#(
   parameter int BLANK_CYC   = 18,
   parameter int NOV_MAX_CYC = 8,
   parameter int CW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    pwm_q,
   input  logic [1:0]    en_q,
   input  logic          sup_q,
   input  logic          hs_off_q,
   input  logic          ls_off_q,
   input  logic          zc_q,
   input  logic [CW-1:0] cnt,
   output logic          clr,
   output logic          hs_on,
   output logic          ls_on
);

   seq_state_e st, nxt;
   cmd_e       pwm_c;
   logic       run, nov_expired, blank_over;

   assign pwm_c       = decode_cmd(pwm_q);
   assign run         = sup_q && (decode_cmd(en_q) == CMD_HIGH);
   assign nov_expired = (cnt == CW'(NOV_MAX_CYC - 1));
   assign blank_over  = (cnt == CW'(BLANK_CYC - 1));

   always_comb begin
      nxt = st;
      if (!run) begin
         nxt = ST_OFF;
      end else begin
         case (pwm_c)
            CMD_HIGH: begin
               case (st)
                  ST_HS_ON:   nxt = ST_HS_ON;
                  ST_WAIT_HS: nxt = (ls_off_q || nov_expired) ? ST_HS_ON : ST_WAIT_HS;
                  default:    nxt = ST_WAIT_HS;
               endcase
            end
            CMD_LOW: begin
               case (st)
                  ST_LS_ON, ST_MID_BLANK, ST_MID_ZC: nxt = ST_LS_ON;
                  ST_WAIT_LS: nxt = (hs_off_q || nov_expired) ? ST_LS_ON : ST_WAIT_LS;
                  default:    nxt = ST_WAIT_LS;
               endcase
            end
            default: begin
               case (st)
                  ST_LS_ON:     nxt = ST_MID_BLANK;
                  ST_WAIT_MID:  nxt = (hs_off_q || nov_expired) ? ST_MID_BLANK : ST_WAIT_MID;
                  ST_MID_BLANK: nxt = blank_over ? (zc_q ? ST_MID_DONE : ST_MID_ZC) : ST_MID_BLANK;
                  ST_MID_ZC:    nxt = zc_q ? ST_MID_DONE : ST_MID_ZC;
                  ST_MID_DONE:  nxt = ST_MID_DONE;
                  default:      nxt = ST_WAIT_MID;
               endcase
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_OFF;
      else        st <= nxt;
   end

   assign clr   = (nxt != st);
   assign hs_on = (st == ST_HS_ON);
   assign ls_on = (st == ST_LS_ON) || (st == ST_MID_BLANK) || (st == ST_MID_ZC);

endmodule

// File: rtl/gdrv_seq.sv
module gdrv_seq #(
   parameter int CLK_PERIOD_PS = 20000,
   parameter int BLANK_NS      = 350,
   parameter int NOV_MAX_CYC   = 8,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwm_cmd,
   input  logic [1:0] en_cmd,
   input  logic       supply_ok,
   input  logic       hs_off_sense,
   input  logic       ls_off_sense,
   input  logic       zc_detect,
   output logic       hs_gate,
   output logic       ls_gate
);

   localparam int BLANK_CYC = (BLANK_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
   localparam int CNT_MAX   = (BLANK_CYC > NOV_MAX_CYC) ? BLANK_CYC : NOV_MAX_CYC;
   localparam int CW        = $clog2(CNT_MAX + 1);
   localparam int SW        = 8;

   if (CLK_PERIOD_PS < 1) begin : g_bad_period
      $error("gdrv_seq: CLK_PERIOD_PS must be positive");
   end
   if (BLANK_CYC < 1) begin : g_bad_blank
      $error("gdrv_seq: blanking must span at least one cycle");
   end
   if (NOV_MAX_CYC < 1) begin : g_bad_nov
      $error("gdrv_seq: NOV_MAX_CYC must be at least 1");
   end

   logic [SW-1:0] sync_in, sync_out;
   logic [1:0]    pwm_q, en_q;
   logic          sup_q, hs_off_q, ls_off_q, zc_q;
   logic          clr;
   logic [CW-1:0] cnt;

   assign sync_in = {pwm_cmd, en_cmd, supply_ok, hs_off_sense, ls_off_sense, zc_detect};
   assign {pwm_q, en_q, sup_q, hs_off_q, ls_off_q, zc_q} = sync_out;

   gdrv_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_in),
      .q     (sync_out)
   );

   gdrv_timer #(.CW(CW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .cnt   (cnt)
   );

   gdrv_fsm #(.BLANK_CYC(BLANK_CYC), .NOV_MAX_CYC(NOV_MAX_CYC), .CW(CW)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_q    (pwm_q),
      .en_q     (en_q),
      .sup_q    (sup_q),
      .hs_off_q (hs_off_q),
      .ls_off_q (ls_off_q),
      .zc_q     (zc_q),
      .cnt      (cnt),
      .clr      (clr),
      .hs_on    (hs_gate),
      .ls_on    (ls_gate)
   );

endmodule

// File: rtl/gdrv_seq_chk.sv
module gdrv_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hs_gate,
   input logic       ls_gate,
   input logic [1:0] pwm_q,
   input logic [1:0] en_q,
   input logic       sup_q
);

   assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));

   assert_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sup_q |=> (!hs_gate && !ls_gate));

   assert_disable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 2'b00) |=> (!hs_gate && !ls_gate));

   assert_brake_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == 2'b01 || en_q == 2'b11) |=> (!hs_gate && !ls_gate));

   assert_hs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> !$past(ls_gate));

   assert_hs_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hs_gate |-> ($past(pwm_q) == 2'b10));

   assert_ls_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate) |-> !$past(hs_gate));

endmodule

bind gdrv_seq gdrv_seq_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hs_gate (hs_gate),
   .ls_gate (ls_gate),
   .pwm_q   (pwm_q),
   .en_q    (en_q),
   .sup_q   (sup_q)
);

// File: tb/tb_gdrv_seq.sv
`timescale 1ns/1ps
module tb_gdrv_seq;

   localparam int BLANK = 18;  // 350 ns at 20 ns per cycle, rounded up (R8)
   localparam int NOV   = 8;   // default NOV_MAX_CYC (R7)

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwm_cmd = 2'b00;
   logic [1:0] en_cmd = 2'b00;
   logic       supply_ok = 1'b1;
   logic       zc_detect = 1'b1;
   logic       stuck_ls = 1'b0;
   logic       hs_off_sense, ls_off_sense;
   logic       hs_gate, ls_gate;

   always #10 clk = ~clk;

   // gate model: a gate reads as off as soon as its enable drops, unless held stuck on
   assign hs_off_sense = !hs_gate;
   assign ls_off_sense = stuck_ls ? 1'b0 : !ls_gate;

   gdrv_seq dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pwm_cmd      (pwm_cmd),
      .en_cmd       (en_cmd),
      .supply_ok    (supply_ok),
      .hs_off_sense (hs_off_sense),
      .ls_off_sense (ls_off_sense),
      .zc_detect    (zc_detect),
      .hs_gate      (hs_gate),
      .ls_gate      (ls_gate)
   );

   typedef struct {
      int    cyc;
      bit    hs;
      bit    ls;
      string tag;
   } exp_t;

   exp_t  sb[$];
   exp_t  item;
   int    cyc = 0;
   int    base = 0;
   int    checks = 0;
   int    failures = 0;
   int    overlaps = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: compare the queued expectation due in this cycle
   always @(negedge clk) begin
      if (hs_gate && ls_gate) overlaps++;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
         item = sb.pop_front();
         checks++;
         if (item.cyc != cyc || hs_gate != item.hs || ls_gate != item.ls) begin
            failures++;
            $display("FAIL %s cycle %0d: hs=%0b ls=%0b expected hs=%0b ls=%0b",
                     item.tag, item.cyc, hs_gate, ls_gate, item.hs, item.ls);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic mark();
      base = cyc;
   endtask

   task automatic expect_at(input int ofs, input bit h, input bit l, input string tag);
      exp_t e;
      e.cyc = base + ofs;
      e.hs  = h;
      e.ls  = l;
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      tick(2);
      mark();
      expect_at(1, 0, 0, "reset R2");
      tick(3);
      rst_n = 1'b1;
      tick(4);

      // R13 R6: enable and low command together from the off state
      en_cmd = 2'b10; pwm_cmd = 2'b00; mark();
      expect_at(3, 0, 0, "latency R13");
      expect_at(4, 0, 1, "ls on R6");
      tick(8);

      // R5: high command, low-side sense follows the dropped gate
      pwm_cmd = 2'b10; mark();
      expect_at(3, 0, 0, "ls drop R5");
      expect_at(5, 0, 0, "waiting sense R5");
      expect_at(6, 1, 0, "hs on R5");
      tick(10);

      // R6: low command from the high-side state
      pwm_cmd = 2'b00; mark();
      expect_at(3, 0, 0, "hs drop R6");
      expect_at(5, 0, 0, "waiting sense R6");
      expect_at(6, 0, 1, "ls on R6");
      tick(10);

      // R12 R8: mid from ls on, zero-cross already present but blanked
      pwm_cmd = 2'b01; mark();
      expect_at(3, 0, 1, "no gap R12");
      expect_at(20, 0, 1, "blank held R8");
      expect_at(3 + BLANK, 0, 0, "blank end cut R8");
      expect_at(28, 0, 0, "latched off R9");
      tick(30);

      // R10: high command clears the mid latch
      pwm_cmd = 2'b10; mark();
      expect_at(4, 1, 0, "leave mid R10");
      tick(8);

      // R8 R9: mid from hs on, no zero-cross until later
      zc_detect = 1'b0;
      tick(4);
      pwm_cmd = 2'b01; mark();
      expect_at(3, 0, 0, "hs drop R8");
      expect_at(5, 0, 0, "wait hs sense R8");
      expect_at(6, 0, 1, "ls on R8");
      expect_at(6 + BLANK, 0, 1, "no zc keeps ls R9");
      expect_at(30, 0, 1, "still no zc R9");
      tick(31);
      zc_detect = 1'b1; mark();
      expect_at(2, 0, 1, "zc sync R9");
      expect_at(3, 0, 0, "zc cut R9");
      tick(6);
      zc_detect = 1'b0;
      tick(4);
      mark();
      expect_at(1, 0, 0, "zc released stays off R9");
      tick(3);
      zc_detect = 1'b1;

      // R10: low then mid again blanks afresh
      pwm_cmd = 2'b00; mark();
      expect_at(4, 0, 1, "ls on R10");
      tick(8);
      pwm_cmd = 2'b01; mark();
      expect_at(2 + BLANK, 0, 1, "reblank R10");
      expect_at(3 + BLANK, 0, 0, "reblank end R10");
      tick(26);

      // R1: code 2'b11 acts as mid
      pwm_cmd = 2'b10; mark();
      expect_at(4, 1, 0, "hs on R1");
      tick(8);
      pwm_cmd = 2'b11; mark();
      expect_at(5, 0, 0, "spare code wait R1");
      expect_at(6, 0, 1, "spare code mid R1");
      tick(30);

      // R7: low-side sense stuck, timeout forces the high side on
      pwm_cmd = 2'b00; mark();
      expect_at(4, 0, 1, "ls on R7");
      tick(8);
      stuck_ls = 1'b1;
      pwm_cmd = 2'b10; mark();
      expect_at(3 + NOV - 1, 0, 0, "before timeout R7");
      expect_at(3 + NOV, 1, 0, "timeout R7");
      tick(14);
      stuck_ls = 1'b0;
      tick(4);

      // R4: mid enable brakes, command changes ignored
      en_cmd = 2'b01; mark();
      expect_at(3, 0, 0, "brake R4");
      tick(6);
      pwm_cmd = 2'b00;
      expect_at(12, 0, 0, "brake ignores pwm R4");
      tick(8);
      en_cmd = 2'b10; mark();
      expect_at(4, 0, 1, "brake exit R4");
      tick(8);

      // R3: low enable disables
      en_cmd = 2'b00; mark();
      expect_at(3, 0, 0, "disable R3");
      tick(4);
      pwm_cmd = 2'b10;
      expect_at(10, 0, 0, "disabled ignores pwm R3");
      tick(8);
      en_cmd = 2'b10; mark();
      expect_at(4, 1, 0, "enable again R3");
      tick(8);

      // R1: enable code 2'b11 acts as mid
      en_cmd = 2'b11; mark();
      expect_at(2, 1, 0, "before latency R1");
      expect_at(3, 0, 0, "enable spare R1");
      tick(6);
      en_cmd = 2'b10; mark();
      expect_at(4, 1, 0, "enable restore R1");
      tick(8);

      // R2: supply lockout
      supply_ok = 1'b0; mark();
      expect_at(3, 0, 0, "lockout R2");
      expect_at(10, 0, 0, "lockout held R2");
      tick(12);
      supply_ok = 1'b1; mark();
      expect_at(4, 1, 0, "supply back R2");
      tick(8);

      // R11: no overlap across the whole run
      checks++;
      if (overlaps != 0) begin
         failures++;
         $display("FAIL R11 overlap cycles=%0d expected 0", overlaps);
      end
      if (sb.size() != 0) begin
         failures++;
         $display("FAIL R13 pending expectations=%0d expected 0", sb.size());
      end
      done = 1'b1;
      summary();
      $finish;
   end

endmodule